// File: doc/BRIEF.md
# Line Error Performance Counters

This block keeps two 16-bit error tallies for a receive-side framer on a T3 or E3 line. The frame tally collects one class of framing event, chosen by a two-bit host field together with the line mode. The parity tally collects T3 parity-bit disagreements. The framer sends single-cycle strobes: loss-of-frame onset, F-bit error, M-bit error, an FAS bit-error count, and FAS word error. For the parity check it sends a valid strobe, the two received parity bits and the locally computed parity.

The host reads both tallies with one latch/clear strobe. In that cycle, each running count is copied into a holding register that the host reads, and the running count starts a new period from zero. A host flag decides whether framing and parity errors are still counted while loss of frame is active. Both tallies stop at their maximum value and do not wrap.

Top module: `lineerr_pmon`

## Requirements
- R1: After reset, both running counts and both holding outputs (`frm_hold`, `par_hold`) are zero.
- R2: With `cnt_sel` = 2'b00, in either mode, the frame count adds 1 for each `lof_onset` strobe and ignores every other event. This source is counted even while `lof_active` is high and `count_in_lof` is 0.
- R3: With `cnt_sel` = 2'b01, T3 mode (`mode_e3` = 0) adds `fbit_err` + `mbit_err`, so it adds 2 when both are high in one cycle. E3 mode (`mode_e3` = 1) adds the value of `fas_bit_errs`.
- R4: With `cnt_sel` = 2'b10, T3 mode adds 1 per `fbit_err` and ignores `mbit_err`. E3 mode adds 1 per `fas_word_err` strobe.
- R5: With `cnt_sel` = 2'b11, T3 mode adds 1 per `mbit_err` and ignores `fbit_err`. E3 mode adds nothing.
- R6: While `lof_active` = 1 and `count_in_lof` = 0, neither the frame count (when `cnt_sel` is not 2'b00) nor the parity count advances. With `count_in_lof` = 1, both count normally during loss of frame.
- R7: In T3 mode, a `par_valid` strobe adds 1 to the parity count when `par_rx_a` differs from `par_rx_b`. It also adds 1 when the two agree but differ from `par_calc`. When all three are equal it adds nothing.
- R8: In E3 mode the parity count holds its value.
- R9: Each count saturates at 16'hFFFF and never wraps.
- R10: On a `latch_clr` cycle, both holding registers take the running counts from before that cycle, and both running counts restart from zero. An event in that same cycle counts in the new period. Outside `latch_clr` cycles the holding registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| mode_e3 | input | 1 | Line mode: 0 = T3, 1 = E3 |
| cnt_sel | input | 2 | Selects the frame count source (see R2 to R5) |
| count_in_lof | input | 1 | 1 = keep counting errors during loss of frame |
| lof_active | input | 1 | Loss of frame is currently asserted |
| lof_onset | input | 1 | Strobe: receive synchronisation was just lost |
| fbit_err | input | 1 | Strobe: T3 F-bit error |
| mbit_err | input | 1 | Strobe: T3 M-bit error |
| fas_bit_errs | input | 4 | Number of errored bits in the E3 FAS word just checked |
| fas_word_err | input | 1 | Strobe: E3 FAS word contained an error |
| par_valid | input | 1 | Strobe: parity inputs are valid this cycle |
| par_rx_a | input | 1 | First received parity bit |
| par_rx_b | input | 1 | Second received parity bit |
| par_calc | input | 1 | Parity computed locally over the payload |
| latch_clr | input | 1 | Host strobe: copy counts to holding registers and restart |
| frm_hold | output | 16 | Frame count from the last completed period |
| par_hold | output | 16 | Parity count from the last completed period |

## Verification
Saturation is the hardest condition to reach from the ports. It needs more than 65,535 counted events with no latch in between. The stimulus gets there quickly by sending, in every cycle, an F-bit and an M-bit error in T3 select 01 (two per cycle) together with a parity mismatch. The run continues past the limit, and the following latch must read 16'hFFFF on both outputs. A second hard case is an event that arrives in the same cycle as `latch_clr`. The bench sends the two together, then latches again to check that the event was counted once, in the new period.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  typedef enum logic [1:0] {
    SEL_LOF    = 2'b00,
    SEL_BOTH   = 2'b01,
    SEL_NARROW = 2'b10,
    SEL_ALT    = 2'b11
  } fe_sel_e;
endpackage

// File: rtl/frame_evt_sel.sv
module frame_evt_sel
  import pmon_pkg::*;
#(
  parameter int FAS_W = 4,
  parameter int INC_W = FAS_W + 1
) (
  input  logic             mode_e3,
  input  logic [1:0]       cnt_sel,
  input  logic             count_in_lof,
  input  logic             lof_active,
  input  logic             lof_onset,
  input  logic             fbit_err,
  input  logic             mbit_err,
  input  logic [FAS_W-1:0] fas_bit_errs,
  input  logic             fas_word_err,
  output logic [INC_W-1:0] inc
);
  fe_sel_e          sel;
  logic [INC_W-1:0] raw;
  logic             muted;

  assign sel = fe_sel_e'(cnt_sel);

  always_comb begin
    raw = '0;
    unique case (sel)
      SEL_LOF:    raw = INC_W'(lof_onset);
      SEL_BOTH:   raw = mode_e3 ? INC_W'(fas_bit_errs)
                                : INC_W'(fbit_err) + INC_W'(mbit_err);
      SEL_NARROW: raw = mode_e3 ? INC_W'(fas_word_err) : INC_W'(fbit_err);
      SEL_ALT:    raw = mode_e3 ? '0 : INC_W'(mbit_err);
      default:    raw = '0;
    endcase
  end

  // loss-of-frame onsets are never muted; error sources are muted by the flag
  assign muted = (sel != SEL_LOF) && lof_active && !count_in_lof;
  assign inc   = muted ? '0 : raw;
endmodule

// File: rtl/parity_chk.sv
module parity_chk (
  input  logic mode_e3,
  input  logic count_in_lof,
  input  logic lof_active,
  input  logic par_valid,
  input  logic par_rx_a,
  input  logic par_rx_b,
  input  logic par_calc,
  output logic par_err
);
  logic mismatch;
  logic allowed;

  assign mismatch = (par_rx_a ^ par_rx_b) | (par_rx_a ^ par_calc);
  assign allowed  = !mode_e3 && !(lof_active && !count_in_lof);
  assign par_err  = par_valid && allowed && mismatch;
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int CNT_W = 16,
  parameter int INC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  input  logic             latch,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] hold_o
);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic [CNT_W-1:0] hold_q, hold_d;
  logic [SUM_W-1:0] sum;
  logic             cnt_en, hold_en;

  always_comb begin
    base    = latch ? '0 : cnt_q;
    sum     = {1'b0, base} + SUM_W'(inc);
    cnt_d   = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    cnt_en  = latch || (inc != '0);
    hold_d  = cnt_q;
    hold_en = latch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/lineerr_pmon.sv
module lineerr_pmon #(
  parameter int CNT_W = 16,
  parameter int FAS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_e3,
  input  logic [1:0]       cnt_sel,
  input  logic             count_in_lof,
  input  logic             lof_active,
  input  logic             lof_onset,
  input  logic             fbit_err,
  input  logic             mbit_err,
  input  logic [FAS_W-1:0] fas_bit_errs,
  input  logic             fas_word_err,
  input  logic             par_valid,
  input  logic             par_rx_a,
  input  logic             par_rx_b,
  input  logic             par_calc,
  input  logic             latch_clr,
  output logic [CNT_W-1:0] frm_hold,
  output logic [CNT_W-1:0] par_hold
);
  localparam int FRM_INC_W = FAS_W + 1;
  localparam int SYNC_D    = 2;

  logic [SYNC_D-1:0]     rst_sync_q;
  logic                  rst_sync_n;
  logic [FRM_INC_W-1:0]  frm_inc;
  logic                  par_err;
  logic [CNT_W-1:0]      frm_live;
  logic [CNT_W-1:0]      par_live;

  // reset: asserted at once, released after SYNC_D clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_D-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[SYNC_D-1];

  frame_evt_sel #(.FAS_W(FAS_W), .INC_W(FRM_INC_W)) u_fsel (
    .mode_e3      (mode_e3),
    .cnt_sel      (cnt_sel),
    .count_in_lof (count_in_lof),
    .lof_active   (lof_active),
    .lof_onset    (lof_onset),
    .fbit_err     (fbit_err),
    .mbit_err     (mbit_err),
    .fas_bit_errs (fas_bit_errs),
    .fas_word_err (fas_word_err),
    .inc          (frm_inc)
  );

  parity_chk u_pchk (
    .mode_e3      (mode_e3),
    .count_in_lof (count_in_lof),
    .lof_active   (lof_active),
    .par_valid    (par_valid),
    .par_rx_a     (par_rx_a),
    .par_rx_b     (par_rx_b),
    .par_calc     (par_calc),
    .par_err      (par_err)
  );

  sat_counter #(.CNT_W(CNT_W), .INC_W(FRM_INC_W)) u_frm_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .inc    (frm_inc),
    .latch  (latch_clr),
    .cnt_o  (frm_live),
    .hold_o (frm_hold)
  );

  sat_counter #(.CNT_W(CNT_W), .INC_W(1)) u_par_cnt (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .inc    (par_err),
    .latch  (latch_clr),
    .cnt_o  (par_live),
    .hold_o (par_hold)
  );
endmodule

// File: rtl/lineerr_pmon_chk.sv
module lineerr_pmon_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             mode_e3,
  input logic [1:0]       cnt_sel,
  input logic             count_in_lof,
  input logic             lof_active,
  input logic             par_valid,
  input logic             par_rx_a,
  input logic             par_rx_b,
  input logic             latch_clr,
  input logic [CNT_W-1:0] frm_live,
  input logic [CNT_W-1:0] par_live,
  input logic [CNT_W-1:0] frm_hold,
  input logic [CNT_W-1:0] par_hold
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R9
  frm_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !latch_clr |=> frm_live >= $past(frm_live));

  // R9
  par_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !latch_clr |=> par_live >= $past(par_live));

  // R10
  frm_latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    latch_clr |=> frm_hold == $past(frm_live));

  // R10
  par_latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    latch_clr |=> par_hold == $past(par_live));

  // R10
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !latch_clr |=> $stable(frm_hold) && $stable(par_hold));

  // R5
  e3_alt_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_e3 && cnt_sel == 2'b11 && !latch_clr) |=> $stable(frm_live));

  // R6
  lof_mute_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lof_active && !count_in_lof && cnt_sel != 2'b00 && !latch_clr)
      |=> $stable(frm_live) && $stable(par_live));

  // R8
  e3_par_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_e3 && !latch_clr) |=> $stable(par_live));

  // R7
  par_split_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mode_e3 && par_valid && (par_rx_a != par_rx_b) && !lof_active &&
     !latch_clr && par_live != CNT_MAX)
      |=> par_live == $past(par_live) + 1'b1);
endmodule

bind lineerr_pmon lineerr_pmon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .mode_e3      (mode_e3),
  .cnt_sel      (cnt_sel),
  .count_in_lof (count_in_lof),
  .lof_active   (lof_active),
  .par_valid    (par_valid),
  .par_rx_a     (par_rx_a),
  .par_rx_b     (par_rx_b),
  .latch_clr    (latch_clr),
  .frm_live     (frm_live),
  .par_live     (par_live),
  .frm_hold     (frm_hold),
  .par_hold     (par_hold)
);

// File: tb/test_lineerr_pmon.sv
module test_lineerr_pmon;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] f;
    logic [15:0] p;
    string       tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_e3 = 1'b0;
  logic [1:0] cnt_sel = 2'b00;
  logic       count_in_lof = 1'b0;
  logic       lof_active = 1'b0;
  logic       lof_onset = 1'b0;
  logic       fbit_err = 1'b0;
  logic       mbit_err = 1'b0;
  logic [3:0] fas_bit_errs = 4'd0;
  logic       fas_word_err = 1'b0;
  logic       par_valid = 1'b0;
  logic       par_rx_a = 1'b0;
  logic       par_rx_b = 1'b0;
  logic       par_calc = 1'b0;
  logic       latch_clr = 1'b0;
  logic [15:0] frm_hold, par_hold;

  int   n_chk = 0;
  int   n_bad = 0;
  int   frm_ref = 0;
  int   par_ref = 0;
  bit   finished = 1'b0;
  exp_t q[$];
  exp_t last_e;

  always #(CLK_PERIOD/2) clk = ~clk;

  lineerr_pmon i_lineerr_pmon (
    .clk(clk), .rst_n(rst_n), .mode_e3(mode_e3), .cnt_sel(cnt_sel),
    .count_in_lof(count_in_lof), .lof_active(lof_active), .lof_onset(lof_onset),
    .fbit_err(fbit_err), .mbit_err(mbit_err), .fas_bit_errs(fas_bit_errs),
    .fas_word_err(fas_word_err), .par_valid(par_valid), .par_rx_a(par_rx_a),
    .par_rx_b(par_rx_b), .par_calc(par_calc), .latch_clr(latch_clr),
    .frm_hold(frm_hold), .par_hold(par_hold)
  );

  function automatic int sat16(int v);
    return (v > 65535) ? 65535 : v;
  endfunction

  // expected increments, taken from the requirement text
  function automatic int exp_frm_inc();
    int r;
    r = 0;
    if (cnt_sel == 2'b00) r = lof_onset;                        // R2
    else if (lof_active && !count_in_lof) r = 0;                // R6
    else if (cnt_sel == 2'b01) r = mode_e3 ? int'(fas_bit_errs)
                                           : int'(fbit_err) + int'(mbit_err); // R3
    else if (cnt_sel == 2'b10) r = mode_e3 ? fas_word_err : fbit_err; // R4
    else r = mode_e3 ? 0 : mbit_err;                            // R5
    return r;
  endfunction

  function automatic int exp_par_inc();
    if (!par_valid || mode_e3 || (lof_active && !count_in_lof)) return 0; // R6 R8
    if (par_rx_a != par_rx_b) return 1;                        // R7
    return (par_rx_a != par_calc) ? 1 : 0;
  endfunction

  // driver: one cycle of stimulus, model update, expectation push on latch
  task automatic tick();
    int fi, pi;
    exp_t e;
    fi = exp_frm_inc();
    pi = exp_par_inc();
    if (latch_clr) begin
      e.f = 16'(frm_ref); e.p = 16'(par_ref); e.tag = cur_tag;
      q.push_back(e);
      frm_ref = sat16(fi);
      par_ref = sat16(pi);
    end else begin
      frm_ref = sat16(frm_ref + fi);
      par_ref = sat16(par_ref + pi);
    end
    @(negedge clk);
    lof_onset = 0; fbit_err = 0; mbit_err = 0; fas_bit_errs = 0;
    fas_word_err = 0; par_valid = 0; latch_clr = 0;
  endtask

  string cur_tag = "";

  task automatic do_latch(string t);
    cur_tag = t;
    latch_clr = 1'b1;
    tick();
  endtask

  task automatic par_ev(logic a, logic b, logic c);
    par_valid = 1'b1; par_rx_a = a; par_rx_b = b; par_calc = c;
    tick();
  endtask

  // monitor: compares holding outputs after each latch cycle
  initial begin
    logic was;
    exp_t e;
    forever begin
      @(posedge clk);
      was = latch_clr;
      @(negedge clk);
      if (was && q.size() > 0) begin
        e = q.pop_front();
        last_e = e;
        n_chk++;
        if (frm_hold !== e.f) begin
          n_bad++;
          $display("FAIL %s frm_hold actual=%0h expected=%0h", e.tag, frm_hold, e.f);
        end
        n_chk++;
        if (par_hold !== e.p) begin
          n_bad++;
          $display("FAIL %s par_hold actual=%0h expected=%0h", e.tag, par_hold, e.p);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog R1..all actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    n_chk++;
    if (frm_hold !== 16'h0 || par_hold !== 16'h0) begin
      n_bad++;
      $display("FAIL R1 reset holds actual=%0h/%0h expected=0/0", frm_hold, par_hold);
    end
    do_latch("R1 reset counts");

    // R2: LOF onsets only, in T3, other events ignored, counted during muted LOF
    mode_e3 = 0; cnt_sel = 2'b00;
    lof_onset = 1; tick();
    fbit_err = 1; mbit_err = 1; tick();
    lof_onset = 1; lof_active = 1; tick();
    lof_onset = 1; tick();
    lof_active = 0;
    do_latch("R2 T3 lof onsets");
    mode_e3 = 1;
    lof_onset = 1; tick();
    fas_word_err = 1; fas_bit_errs = 4'd5; tick();
    do_latch("R2 E3 lof onsets");

    // R3 + R7: T3 select 01 and parity patterns
    mode_e3 = 0; cnt_sel = 2'b01;
    fbit_err = 1; tick();
    mbit_err = 1; tick();
    fbit_err = 1; mbit_err = 1; tick();
    fbit_err = 1; tick();
    par_ev(1, 0, 1);
    par_ev(0, 0, 1);
    par_ev(1, 1, 1);
    par_ev(0, 0, 0);
    do_latch("R3 R7 T3 both bits and parity");

    // R3 + R8: E3 select 01 bit counts; parity ignored in E3
    mode_e3 = 1;
    fas_bit_errs = 4'd3; tick();
    fas_bit_errs = 4'd15; tick();
    par_ev(1, 0, 0);
    fbit_err = 1; tick();
    do_latch("R3 R8 E3 fas bits");

    // R4: select 10
    mode_e3 = 0; cnt_sel = 2'b10;
    fbit_err = 1; tick();
    mbit_err = 1; tick();
    fbit_err = 1; mbit_err = 1; tick();
    do_latch("R4 T3 f only");
    mode_e3 = 1;
    fas_word_err = 1; fas_bit_errs = 4'd4; tick();
    fas_word_err = 1; tick();
    do_latch("R4 E3 word errors");

    // R5: select 11
    mode_e3 = 0; cnt_sel = 2'b11;
    mbit_err = 1; tick();
    fbit_err = 1; tick();
    mbit_err = 1; fbit_err = 1; tick();
    do_latch("R5 T3 m only");
    mode_e3 = 1;
    mbit_err = 1; fas_word_err = 1; fas_bit_errs = 4'd9; lof_onset = 1; tick();
    do_latch("R5 E3 illegal select");

    // R6: muting during loss of frame
    mode_e3 = 0; cnt_sel = 2'b01; lof_active = 1; count_in_lof = 0;
    fbit_err = 1; mbit_err = 1; tick();
    par_ev(1, 0, 0);
    do_latch("R6 muted in lof");
    count_in_lof = 1;
    fbit_err = 1; tick();
    par_ev(1, 0, 0);
    do_latch("R6 counted in lof");
    lof_active = 0; count_in_lof = 0;

    // R10: event in the latch cycle starts the new period
    fbit_err = 1; tick();
    fbit_err = 1; par_valid = 1; par_rx_a = 1; par_rx_b = 0;
    do_latch("R10 prior period");
    mbit_err = 1; tick();
    // R10: holds unchanged between latches
    n_chk++;
    if (frm_hold !== last_e.f || par_hold !== last_e.p) begin
      n_bad++;
      $display("FAIL R10 hold steady actual=%0h/%0h expected=%0h/%0h",
               frm_hold, par_hold, last_e.f, last_e.p);
    end
    do_latch("R10 same cycle event in new period");

    // R9: saturation of both counts
    for (int i = 0; i < 65540; i++) begin
      fbit_err = 1; mbit_err = 1;
      par_valid = 1; par_rx_a = 0; par_rx_b = 1;
      tick();
    end
    do_latch("R9 saturated");
    fbit_err = 1; tick();
    do_latch("R9 R10 restart after saturation");

    repeat (3) @(negedge clk);
    n_chk++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R10 pending latches actual=%0d expected=0", q.size());
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule